// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller decides which low-power depth the core drops into when it executes a sleep instruction, and gates the clocks of the units that depth stops. When a sleep request arrives, it samples a select bit in each of two standby control registers. The first register's bit selects standby, the deepest mode. If that bit is clear, the second register's bit selects deep sleep. With both bits clear, the core goes into plain sleep. The chosen depth decides which of three clock enables fall: the CPU enable, the DMA enable, and the enable for the timer, serial and power-management group.

While the core is in any low-power mode, events that fall due are still serviced, and servicing one does not wake the core. Only an interrupt, or the wake-reset input, returns the controller to running. When that happens, the controller raises a one-cycle wake pulse and restores every clock enable at the same time.

On entry to standby, the peripheral group gets one last enabled cycle, marked by a sync pulse. This lets the group bring its state up to date before its clock stops.

Top module: `lowpower_ctl`

## Requirements
- R1: After reset, mode is 0 (running), all three clock enables are 1, and wake_pulse, per_sync and ev_svc are 0.
- R2: A sleep_req sampled while running sets mode on the next cycle. The mode is 3 (standby) if bit 7 of stby_ctl1 is 1. Otherwise it is 2 (deep sleep) if bit 7 of stby_ctl2 is 1. Otherwise it is 1 (sleep). All other bits of both registers have no effect.
- R3: cpu_clk_en is 0 in modes 1, 2 and 3, and 1 in mode 0.
- R4: dma_clk_en is 0 in modes 2 and 3, and 1 in modes 0 and 1.
- R5: In the first cycle of standby, per_sync is 1 and per_clk_en is still 1. In every later cycle of standby, per_sync is 0 and per_clk_en is 0.
- R6: per_clk_en stays 1 in modes 0, 1 and 2.
- R7: irq or wake_rst sampled in a non-running mode gives, on the next cycle, mode 0, all enables 1 and wake_pulse 1. wake_pulse is 0 again on the cycle after that.
- R8: A sleep_req sampled in a non-running mode leaves the mode unchanged. irq sampled while running causes no wake_pulse.
- R9: ev_due sampled in a non-running mode gives ev_svc 1 on the next cycle and does not change the mode. While running, ev_svc stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Sleep instruction executed |
| stby_ctl1 | input | 8 | First standby control register; bit 7 selects standby |
| stby_ctl2 | input | 8 | Second standby control register; bit 7 selects deep sleep |
| irq | input | 1 | Interrupt pending |
| wake_rst | input | 1 | Reset request that wakes the core |
| ev_due | input | 1 | A timed event has fallen due |
| mode | output | 2 | 0 running, 1 sleep, 2 deep sleep, 3 standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| dma_clk_en | output | 1 | DMA clock enable |
| per_clk_en | output | 1 | Timer/serial/power peripheral clock enable |
| per_sync | output | 1 | Peripheral catch-up pulse on standby entry |
| wake_pulse | output | 1 | One-cycle pulse on return to running |
| ev_svc | output | 1 | Event serviced while asleep |

## Verification
The sweep covers all four combinations of the two select bits. Each combination is repeated under several fill patterns of the other register bits, which separates a correct priority decode from one that reads the wrong bit or ignores the first register. Every depth is then woken once by irq and once by wake_rst, to show that both sources restore all enables.

Between entry and wake, three further inputs are applied in the low-power mode. A second sleep_req with different select bits confirms that the mode holds. An ev_due confirms that servicing does not wake the core. A plain idle cycle separates the standby catch-up cycle from the stopped state that follows it.

// File: rtl/lowpower_ctl.sv
module lowpower_ctl #(
  parameter int CW      = 8,
  parameter int SEL_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_req,
  input  logic [CW-1:0] stby_ctl1,
  input  logic [CW-1:0] stby_ctl2,
  input  logic          irq,
  input  logic          wake_rst,
  input  logic          ev_due,
  output logic [1:0]    mode,
  output logic          cpu_clk_en,
  output logic          dma_clk_en,
  output logic          per_clk_en,
  output logic          per_sync,
  output logic          wake_pulse,
  output logic          ev_svc
);
  localparam logic [1:0] M_RUN  = 2'd0;
  localparam logic [1:0] M_SLP  = 2'd1;
  localparam logic [1:0] M_DEEP = 2'd2;
  localparam logic [1:0] M_STBY = 2'd3;

  logic       asleep;
  logic [1:0] depth;

  assign asleep = (mode != M_RUN);
  assign depth  = stby_ctl1[SEL_BIT] ? M_STBY :
                  stby_ctl2[SEL_BIT] ? M_DEEP : M_SLP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_RUN;
      wake_pulse <= 1'b0;
      per_sync   <= 1'b0;
      ev_svc     <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      per_sync   <= 1'b0;
      ev_svc     <= asleep && ev_due;
      if (!asleep) begin
        if (sleep_req) begin
          mode     <= depth;
          per_sync <= (depth == M_STBY);
        end
      end else if (irq || wake_rst) begin
        mode       <= M_RUN;
        wake_pulse <= 1'b1;
      end
    end
  end

  assign cpu_clk_en = (mode == M_RUN);
  assign dma_clk_en = (mode == M_RUN) || (mode == M_SLP);
  assign per_clk_en = (mode != M_STBY) || per_sync;
endmodule

module lowpower_ctl_chk #(
  parameter int CW      = 8,
  parameter int SEL_BIT = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_req,
  input logic [CW-1:0] stby_ctl1,
  input logic [CW-1:0] stby_ctl2,
  input logic          irq,
  input logic          wake_rst,
  input logic          ev_due,
  input logic [1:0]    mode,
  input logic          cpu_clk_en,
  input logic          dma_clk_en,
  input logic          per_clk_en,
  input logic          per_sync,
  input logic          wake_pulse,
  input logic          ev_svc
);
  // R2
  stby_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sleep_req && stby_ctl1[SEL_BIT]) |=> (mode == 2'd3));
  // R2
  deep_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sleep_req && !stby_ctl1[SEL_BIT] && stby_ctl2[SEL_BIT]) |=> (mode == 2'd2));
  // R5
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_sync |=> !per_sync);
  // R7
  wake_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && (irq || wake_rst)) |=> (wake_pulse && cpu_clk_en && dma_clk_en && per_clk_en));
  // R8
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && !irq && !wake_rst) |=> $stable(mode));
  // R9
  ev_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && ev_due) |=> ev_svc);
endmodule

bind lowpower_ctl lowpower_ctl_chk #(.CW(CW), .SEL_BIT(SEL_BIT)) u_chk (.*);

// File: tb/lowpower_ctl_bench.sv
`timescale 1ns/1ps
module lowpower_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic [7:0] stby_ctl1 = 8'h00;
  logic [7:0] stby_ctl2 = 8'h00;
  logic       irq = 1'b0;
  logic       wake_rst = 1'b0;
  logic       ev_due = 1'b0;
  logic [1:0] mode;
  logic       cpu_clk_en, dma_clk_en, per_clk_en, per_sync, wake_pulse, ev_svc;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lowpower_ctl u_lowpower_ctl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .stby_ctl1(stby_ctl1), .stby_ctl2(stby_ctl2),
    .irq(irq), .wake_rst(wake_rst), .ev_due(ev_due),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .dma_clk_en(dma_clk_en),
    .per_clk_en(per_clk_en), .per_sync(per_sync),
    .wake_pulse(wake_pulse), .ev_svc(ev_svc)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    sleep_req = 1'b0; irq = 1'b0; wake_rst = 1'b0; ev_due = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    quiet();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] fills [4];
    fills[0] = 8'h00; fills[1] = 8'h7F; fills[2] = 8'h55; fills[3] = 8'h2A;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 mode", mode, 0);
    chk("R1 cpu_en", cpu_clk_en, 1);
    chk("R1 dma_en", dma_clk_en, 1);
    chk("R1 per_en", per_clk_en, 1);
    chk("R1 pulses", {wake_pulse, per_sync, ev_svc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 irq while running; R9 ev_due while running
    irq = 1'b1; ev_due = 1'b1;
    step();
    chk("R8 irq running wake", wake_pulse, 0);
    chk("R9 running ev_svc", ev_svc, 0);
    chk("R8 irq running mode", mode, 0);
    for (int c1 = 0; c1 < 2; c1++)
      for (int c2 = 0; c2 < 2; c2++)
        for (int f = 0; f < 4; f++)
          for (int wk = 0; wk < 2; wk++) begin
            int tgt;
            tgt = (c1 != 0) ? 3 : ((c2 != 0) ? 2 : 1);
            stby_ctl1 = {c1[0], fills[f][6:0]};
            stby_ctl2 = {c2[0], fills[3-f][6:0]};
            sleep_req = 1'b1;
            step();
            // R2
            chk("R2 depth", mode, tgt);
            // R3
            chk("R3 cpu_en", cpu_clk_en, 0);
            // R4
            chk("R4 dma_en", dma_clk_en, (tgt == 1) ? 1 : 0);
            // R5 / R6 first cycle
            chk("R5 R6 per_en entry", per_clk_en, 1);
            chk("R5 sync entry", per_sync, (tgt == 3) ? 1 : 0);
            step();
            chk("R5 R6 per_en later", per_clk_en, (tgt == 3) ? 0 : 1);
            chk("R5 sync later", per_sync, 0);
            // R8 second request with inverted selects
            stby_ctl1 = ~stby_ctl1; stby_ctl2 = ~stby_ctl2;
            sleep_req = 1'b1;
            step();
            chk("R8 sleep ignored", mode, tgt);
            chk("R8 no sync", per_sync, 0);
            // R9
            ev_due = 1'b1;
            step();
            chk("R9 ev_svc", ev_svc, 1);
            chk("R9 mode kept", mode, tgt);
            chk("R9 no wake", wake_pulse, 0);
            // R7
            if (wk == 0) irq = 1'b1; else wake_rst = 1'b1;
            step();
            chk("R7 mode", mode, 0);
            chk("R7 wake", wake_pulse, 1);
            chk("R7 enables", {cpu_clk_en, dma_clk_en, per_clk_en}, 7);
            step();
            chk("R7 wake single", wake_pulse, 0);
            chk("R9 svc cleared", ev_svc, 0);
          end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule